// File: doc/BRIEF.md
# LRU Detiler Register Allocator

This block hands out a small pool of detiler range registers to requesters. It keeps every register it owns in a recency list, with the least recently used entry at the head and the most recently used at the tail. It also keeps a saturating pin count per register. A separate busy vector from outside marks registers whose previous user is still working through them. The block never programs register contents and never waits for a busy register to go idle. It only decides which index to hand out, in what order, and when to refuse.

An allocation starts a scan that examines one list position per clock, starting at the head. Idle, unpinned registers are preferred. A busy register met during the scan moves to the tail and is remembered as a fallback. When that fallback comes around a second time, the preference for idle registers is dropped and any unpinned register is taken. Single-cycle commands cover the rest of the work: re-touching an owned register, unpinning, releasing a register to the head, lending a register to an external agent (it leaves the list), and taking a lent register back. Each command produces exactly one response pulse that carries a status code, an index and the resulting pin count.

Top module: `lru_detile_alloc`

## Requirements
- R1: After reset the list holds every register in index order with index 0 at the head, all pin counts are zero, `cmd_ready` is 1 and `rsp_valid` is 0, so a first allocation with no busy register returns index 0.
- R2: An allocation (`cmd_op`=0) returns the entry nearest the head that is neither busy nor pinned. That entry's pin count becomes 1 and the entry moves to the tail. The status is OK (0).
- R3: While the idle preference holds, each busy entry met by the scan moves to the tail. The first one met is kept as a fallback. Once the fallback is met again, the preference ends, so with every unpinned entry busy the allocation returns the first busy entry the scan met.
- R4: Pinned entries are always skipped. When the scan runs past the list end it responds RETRY (1) if `release_pending_i` is high, and NO_RESOURCE (2) otherwise.
- R5: A scan takes one clock per examined list position plus one for the end-of-list test. `cmd_ready` stays low until the response. Every accepted command yields exactly one `rsp_valid` pulse. Single-cycle commands respond one clock after acceptance.
- R6: A touch (`cmd_op`=1) of a listed register adds one to its pin count, saturating at 2^PIN_W-1, and moves it to the tail. Touching a lent register gives ERROR (3).
- R7: An unpin (`cmd_op`=2) subtracts one from the pin count. An unpin at count zero gives ERROR (3) and leaves the count at zero.
- R8: A release (`cmd_op`=3) of a listed, unpinned register moves it to the head. A release of a pinned or lent register gives ERROR (3).
- R9: A lend (`cmd_op`=4) responds NO_RESOURCE (2) one clock after acceptance unless at least two listed registers are unpinned. Otherwise it scans like an allocation, removes the chosen entry from the list and leaves its pin count at 0.
- R10: A take-back (`cmd_op`=5) puts a lent register back at the head, so it is the next idle choice. Taking back a listed register gives ERROR (3).
- R11: For touch, unpin, release and take-back `rsp_idx` echoes the command index. For OK touch and unpin `rsp_pin` is the new pin count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_ready | output | 1 | High when no scan is running |
| cmd_op | input | 3 | 0 allocate, 1 touch, 2 unpin, 3 release, 4 lend, 5 take back |
| cmd_idx | input | $clog2(NUM_REGS) | Register index for touch, unpin, release, take back |
| busy_i | input | NUM_REGS | Per-register busy flags |
| release_pending_i | input | 1 | A release is expected soon; turns a failed scan into RETRY |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_status | output | 2 | 0 OK, 1 RETRY, 2 NO_RESOURCE, 3 ERROR |
| rsp_idx | output | $clog2(NUM_REGS) | Chosen or echoed register index |
| rsp_pin | output | PIN_W | Pin count after the command |

## Verification
A corrupted recency list shows at the ports as a wrong index on the next allocation. It also shows as a scan whose length differs from the count of positions a correct list would need, so it is caught on the very next allocation or lend. A wrong pin count shows at once in `rsp_pin` on touch and unpin. It shows as an ERROR where OK was due on unpin or release, or as a pinned register being handed out. A wrong membership flag shows as ERROR on touch or take-back, or as a lent register being returned by an allocation. The bench keeps its own list, pin and membership model and compares every response, including latency, across a long mixed command stream on an 8-entry pool.

// File: rtl/lru_alloc_pkg.sv
package lru_alloc_pkg;

   localparam logic [2:0] OP_ALLOC   = 3'd0;
   localparam logic [2:0] OP_TOUCH   = 3'd1;
   localparam logic [2:0] OP_UNPIN   = 3'd2;
   localparam logic [2:0] OP_RELEASE = 3'd3;
   localparam logic [2:0] OP_LEND    = 3'd4;
   localparam logic [2:0] OP_TAKE    = 3'd5;

   localparam logic [1:0] ST_OK    = 2'd0;
   localparam logic [1:0] ST_RETRY = 2'd1;
   localparam logic [1:0] ST_NORES = 2'd2;
   localparam logic [1:0] ST_ERR   = 2'd3;

   typedef enum logic [2:0] {
      ED_NONE,
      ED_TO_TAIL,
      ED_TO_HEAD,
      ED_DROP,
      ED_ADD_HEAD
   } edit_e;

   typedef enum logic {
      S_IDLE,
      S_SCAN
   } fsm_e;

endpackage

// File: rtl/lru_order_list.sv
module lru_order_list
   import lru_alloc_pkg::*;
#(
   parameter int NUM = 16,
   localparam int IW = $clog2(NUM),
   localparam int LW = $clog2(NUM + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  edit_e                   edit,
   input  logic [IW-1:0]           edit_pos,
   input  logic [IW-1:0]           edit_id,
   output logic [NUM-1:0][IW-1:0]  order,
   output logic [LW-1:0]           len,
   output logic [NUM-1:0]          member
);

   logic [NUM-1:0][IW-1:0] order_n;
   logic [LW-1:0]          len_n;
   logic [NUM-1:0]         member_n;

   always_comb begin
      order_n  = order;
      len_n    = len;
      member_n = member;
      for (int j = 0; j < NUM; j++) begin
         int jn;
         int jp;
         jn = (j + 1 < NUM) ? j + 1 : j;
         jp = (j > 0) ? j - 1 : 0;
         unique case (edit)
            ED_TO_TAIL: begin
               if (j >= int'(edit_pos) && j + 1 < int'(len)) order_n[j] = order[jn];
               else if (j + 1 == int'(len))                 order_n[j] = order[edit_pos];
            end
            ED_TO_HEAD: begin
               if (j == 0)                      order_n[j] = order[edit_pos];
               else if (j <= int'(edit_pos))    order_n[j] = order[jp];
            end
            ED_DROP: begin
               if (j >= int'(edit_pos) && j + 1 < int'(len)) order_n[j] = order[jn];
            end
            ED_ADD_HEAD: begin
               if (j == 0)                 order_n[j] = edit_id;
               else if (j <= int'(len))    order_n[j] = order[jp];
            end
            default: ;
         endcase
      end
      if (edit == ED_DROP) begin
         len_n                     = len - LW'(1);
         member_n[order[edit_pos]] = 1'b0;
      end else if (edit == ED_ADD_HEAD) begin
         len_n             = len + LW'(1);
         member_n[edit_id] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < NUM; j++) order[j] <= IW'(j);
         len    <= LW'(NUM);
         member <= '1;
      end else begin
         order  <= order_n;
         len    <= len_n;
         member <= member_n;
      end
   end

   // R9: list length and membership flags are kept apart and must agree
   p_len_members_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(len) == $countones(member));

   // R9: only a listed entry can be dropped
   p_drop_listed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (edit == ED_DROP) |-> (member[order[edit_pos]] && len != '0));

   // R10: only an entry outside the list can be added back
   p_add_absent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (edit == ED_ADD_HEAD) |-> !member[edit_id]);

endmodule

// File: rtl/lru_pin_table.sv
module lru_pin_table #(
   parameter int NUM   = 16,
   parameter int PIN_W = 4,
   localparam int IW = $clog2(NUM),
   localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inc_en,
   input  logic [IW-1:0]            inc_id,
   input  logic                     dec_en,
   input  logic [IW-1:0]            dec_id,
   output logic [NUM-1:0][PIN_W-1:0] pins,
   output logic [NUM-1:0]           pinned
);

   for (genvar g = 0; g < NUM; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pins[g] <= '0;
         end else if (inc_en && inc_id == IW'(g)) begin
            if (pins[g] != PIN_MAX) pins[g] <= pins[g] + PIN_W'(1);
         end else if (dec_en && dec_id == IW'(g)) begin
            pins[g] <= pins[g] - PIN_W'(1);
         end
      end
      assign pinned[g] = |pins[g];
   end

   // R7: the controller never asks for a decrement at zero
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |-> pins[dec_id] != '0);

   // R6: a saturated count stays saturated after an increment
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && pins[inc_id] == PIN_MAX) |=> pins[$past(inc_id)] == PIN_MAX);

   // R5: one pin update per cycle at most
   p_single_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc_en && dec_en));

endmodule

// File: rtl/lru_detile_alloc.sv
module lru_detile_alloc
   import lru_alloc_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int PIN_W    = 4,
   localparam int IW = $clog2(NUM_REGS),
   localparam int LW = $clog2(NUM_REGS + 1),
   localparam int SW = $clog2(2 * NUM_REGS + 2),
   localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [2:0]           cmd_op,
   input  logic [IW-1:0]        cmd_idx,
   input  logic [NUM_REGS-1:0]  busy_i,
   input  logic                 release_pending_i,
   output logic                 rsp_valid,
   output logic [1:0]           rsp_status,
   output logic [IW-1:0]        rsp_idx,
   output logic [PIN_W-1:0]     rsp_pin
);

   if (!(NUM_REGS == 8 || NUM_REGS == 16 || NUM_REGS == 32)) begin : g_bad_num
      $error("NUM_REGS must be 8, 16 or 32");
   end
   if (PIN_W < 1 || PIN_W > 16) begin : g_bad_pin
      $error("PIN_W must be 1 to 16");
   end

   logic [NUM_REGS-1:0][IW-1:0]    order;
   logic [LW-1:0]                  len;
   logic [NUM_REGS-1:0]            member;
   logic [NUM_REGS-1:0][PIN_W-1:0] pins;
   logic [NUM_REGS-1:0]            pinned;

   edit_e         edit;
   logic [IW-1:0] edit_pos, edit_id;
   logic          inc_en, dec_en;
   logic [IW-1:0] inc_id, dec_id;

   fsm_e          state, state_n;
   logic [LW-1:0] scan_pos, pos_n;
   logic [IW-1:0] fb_id, fb_n;
   logic          fb_valid, fbv_n, prefer, pref_n, scan_lend, lend_n;
   logic [SW-1:0] scan_steps;

   logic          rsp_n;
   logic [1:0]    stat_n;
   logic [IW-1:0] idx_n;
   logic [PIN_W-1:0] pin_n;
   logic [2:0]    rsp_op, op_n;

   logic [IW-1:0] hit_pos, cur;
   logic          twice;
   int            free_cnt;

   lru_order_list #(.NUM(NUM_REGS)) i_list (
      .clk, .rst_n, .edit, .edit_pos, .edit_id, .order, .len, .member
   );

   lru_pin_table #(.NUM(NUM_REGS), .PIN_W(PIN_W)) i_pins (
      .clk, .rst_n, .inc_en, .inc_id, .dec_en, .dec_id, .pins, .pinned
   );

   always_comb begin
      hit_pos = '0;
      for (int j = 0; j < NUM_REGS; j++)
         if (j < int'(len) && order[j] == cmd_idx) hit_pos = IW'(j);
   end

   assign free_cnt  = $countones(member & ~pinned);
   assign cur       = order[scan_pos[IW-1:0]];
   assign twice     = fb_valid && fb_id == cur;
   assign cmd_ready = (state == S_IDLE);

   always_comb begin
      edit = ED_NONE; edit_pos = '0; edit_id = '0;
      inc_en = 1'b0; inc_id = '0; dec_en = 1'b0; dec_id = '0;
      state_n = state; pos_n = scan_pos; fb_n = fb_id; fbv_n = fb_valid;
      pref_n = prefer; lend_n = scan_lend;
      rsp_n = 1'b0; stat_n = ST_OK; idx_n = cmd_idx; pin_n = pins[cmd_idx]; op_n = rsp_op;
      if (state == S_IDLE) begin
         if (cmd_valid) begin
            op_n  = cmd_op;
            rsp_n = 1'b1;
            case (cmd_op)
               OP_ALLOC, OP_LEND: begin
                  if (cmd_op == OP_LEND && free_cnt < 2) begin
                     stat_n = ST_NORES;
                  end else begin
                     rsp_n   = 1'b0;
                     state_n = S_SCAN;
                     pos_n   = '0;
                     fbv_n   = 1'b0;
                     pref_n  = 1'b1;
                     lend_n  = (cmd_op == OP_LEND);
                  end
               end
               OP_TOUCH: begin
                  if (member[cmd_idx]) begin
                     inc_en = 1'b1; inc_id = cmd_idx;
                     edit = ED_TO_TAIL; edit_pos = hit_pos;
                     pin_n = (pins[cmd_idx] == PIN_MAX) ? PIN_MAX : pins[cmd_idx] + PIN_W'(1);
                  end else stat_n = ST_ERR;
               end
               OP_UNPIN: begin
                  if (pinned[cmd_idx]) begin
                     dec_en = 1'b1; dec_id = cmd_idx;
                     pin_n = pins[cmd_idx] - PIN_W'(1);
                  end else stat_n = ST_ERR;
               end
               OP_RELEASE: begin
                  if (member[cmd_idx] && !pinned[cmd_idx]) begin
                     edit = ED_TO_HEAD; edit_pos = hit_pos;
                  end else stat_n = ST_ERR;
               end
               OP_TAKE: begin
                  if (!member[cmd_idx]) begin
                     edit = ED_ADD_HEAD; edit_id = cmd_idx;
                  end else stat_n = ST_ERR;
               end
               default: stat_n = ST_ERR;
            endcase
         end
      end else begin
         if (scan_pos >= len) begin
            rsp_n   = 1'b1;
            stat_n  = release_pending_i ? ST_RETRY : ST_NORES;
            state_n = S_IDLE;
         end else if (prefer && !twice && busy_i[cur]) begin
            edit = ED_TO_TAIL; edit_pos = scan_pos[IW-1:0];
            if (!fb_valid) begin
               fbv_n = 1'b1; fb_n = cur;
            end
         end else begin
            if (twice) pref_n = 1'b0;
            if (pinned[cur]) begin
               pos_n = scan_pos + LW'(1);
            end else begin
               rsp_n    = 1'b1;
               idx_n    = cur;
               state_n  = S_IDLE;
               edit_pos = scan_pos[IW-1:0];
               if (scan_lend) begin
                  edit  = ED_DROP;
                  pin_n = '0;
               end else begin
                  edit   = ED_TO_TAIL;
                  inc_en = 1'b1; inc_id = cur;
                  pin_n  = PIN_W'(1);
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE; scan_pos <= '0; fb_id <= '0; fb_valid <= 1'b0;
         prefer <= 1'b1; scan_lend <= 1'b0; scan_steps <= '0;
         rsp_valid <= 1'b0; rsp_status <= ST_OK; rsp_idx <= '0; rsp_pin <= '0;
         rsp_op <= OP_ALLOC;
      end else begin
         state <= state_n; scan_pos <= pos_n; fb_id <= fb_n; fb_valid <= fbv_n;
         prefer <= pref_n; scan_lend <= lend_n;
         scan_steps <= (state == S_SCAN) ? scan_steps + SW'(1) : '0;
         rsp_valid <= rsp_n;
         rsp_op    <= op_n;
         if (rsp_n) begin
            rsp_status <= stat_n; rsp_idx <= idx_n; rsp_pin <= pin_n;
         end
      end
   end

   // R2: a granted allocation is pinned, listed and sits at the tail
   p_alloc_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op == OP_ALLOC && rsp_status == ST_OK) |->
      (pinned[rsp_idx] && member[rsp_idx] && order[IW'(len - LW'(1))] == rsp_idx));

   // R9: a lent register has left the list and is unpinned
   p_lend_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op == OP_LEND && rsp_status == ST_OK) |->
      (!member[rsp_idx] && !pinned[rsp_idx]));

   // R10: a taken-back register is at the head
   p_take_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op == OP_TAKE && rsp_status == ST_OK) |->
      (member[rsp_idx] && order[0] == rsp_idx));

   // R5: a scan always ends within two passes of the list
   p_scan_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SCAN) |-> int'(scan_steps) <= 2 * NUM_REGS + 1);

   // R5: no response while a scan is still in progress
   p_one_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SCAN && $past(state) == S_SCAN) |-> !rsp_valid);

endmodule

// File: tb/test_lru_detile_alloc.sv
module test_lru_detile_alloc;

   localparam int CLK_PERIOD = 10;
   localparam int N     = 8;
   localparam int PIN_W = 2;
   localparam int IW    = $clog2(N);
   localparam int PMAX  = (1 << PIN_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [2:0] cmd_op = '0;
   logic [IW-1:0] cmd_idx = '0;
   logic [N-1:0] busy_i = '0;
   logic release_pending_i = 1'b0;
   logic rsp_valid;
   logic [1:0] rsp_status;
   logic [IW-1:0] rsp_idx;
   logic [PIN_W-1:0] rsp_pin;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   int m_ord [N];
   int m_len;
   int m_pin [N];
   bit m_mem [N];

   lru_detile_alloc #(.NUM_REGS(N), .PIN_W(PIN_W)) i_lru_detile_alloc (
      .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_idx, .busy_i,
      .release_pending_i, .rsp_valid, .rsp_status, .rsp_idx, .rsp_pin
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic m_to_tail(input int p);
      int t = m_ord[p];
      for (int j = p; j < m_len - 1; j++) m_ord[j] = m_ord[j + 1];
      m_ord[m_len - 1] = t;
   endtask

   task automatic m_to_head(input int p);
      int t = m_ord[p];
      for (int j = p; j > 0; j--) m_ord[j] = m_ord[j - 1];
      m_ord[0] = t;
   endtask

   task automatic m_drop(input int p);
      for (int j = p; j < m_len - 1; j++) m_ord[j] = m_ord[j + 1];
      m_len--;
   endtask

   task automatic m_add_head(input int id);
      for (int j = m_len; j > 0; j--) m_ord[j] = m_ord[j - 1];
      m_ord[0] = id;
      m_len++;
   endtask

   function automatic int m_find(input int id);
      for (int j = 0; j < m_len; j++) if (m_ord[j] == id) return j;
      return -1;
   endfunction

   // op codes: 0 alloc, 1 touch, 2 unpin, 3 release, 4 lend, 5 take back
   // status: 0 OK, 1 RETRY, 2 NO_RESOURCE, 3 ERROR
   task automatic run_op(input int op, input int idx, input logic [N-1:0] bz, input bit pend,
                         input string force_tag);
      int exp_st, exp_idx, exp_pin, exp_lat, lat;
      bit c_idx, c_pin, is_scan, ready_bad;
      string tag;
      exp_st = 0; exp_idx = idx; exp_pin = 0; c_idx = 1; c_pin = 0; is_scan = 0;
      exp_lat = 1; tag = "R11";
      if (op == 0 || op == 4) begin
         int free_n = 0;
         for (int j = 0; j < N; j++) if (m_mem[j] && m_pin[j] == 0) free_n++;
         tag = (op == 0) ? "R2" : "R9";
         if (op == 4 && free_n < 2) begin
            exp_st = 2; c_idx = 0;
         end else begin
            int p = 0, fb = -1, steps = 0, found = -1;
            bit pref = 1;
            is_scan = 1;
            while (1) begin
               int e;
               bit tw;
               steps++;
               if (p >= m_len) break;
               e = m_ord[p];
               tw = (fb == e);
               if (pref && !tw && bz[e]) begin
                  m_to_tail(p);
                  if (fb < 0) fb = e;
                  continue;
               end
               if (tw) pref = 0;
               if (m_pin[e] != 0) begin
                  p++;
                  continue;
               end
               found = e;
               break;
            end
            exp_lat = 1 + steps;
            if (found < 0) begin
               exp_st = pend ? 1 : 2; c_idx = 0;
               if (op == 0) tag = "R4";
            end else begin
               exp_idx = found; c_pin = 1;
               if (op == 0) begin
                  m_pin[found] = 1; m_to_tail(p); exp_pin = 1;
                  if (fb >= 0) tag = "R3";
               end else begin
                  m_drop(p); m_mem[found] = 0; exp_pin = 0;
               end
            end
         end
      end else if (op == 1) begin
         tag = "R6";
         if (!m_mem[idx]) exp_st = 3;
         else begin
            if (m_pin[idx] < PMAX) m_pin[idx]++;
            m_to_tail(m_find(idx)); exp_pin = m_pin[idx]; c_pin = 1;
         end
      end else if (op == 2) begin
         tag = "R7";
         if (m_pin[idx] == 0) exp_st = 3;
         else begin
            m_pin[idx]--; exp_pin = m_pin[idx]; c_pin = 1;
         end
      end else if (op == 3) begin
         tag = "R8";
         if (!m_mem[idx] || m_pin[idx] != 0) exp_st = 3;
         else m_to_head(m_find(idx));
      end else begin
         tag = "R10";
         if (m_mem[idx]) exp_st = 3;
         else begin
            m_add_head(idx); m_mem[idx] = 1;
         end
      end
      if (force_tag != "") tag = force_tag;

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_idx = idx[IW-1:0];
      busy_i = bz; release_pending_i = pend;
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1; ready_bad = 0;
      while (!rsp_valid && lat < 200) begin
         if (cmd_ready) ready_bad = 1;
         @(negedge clk);
         lat++;
      end
      chk(tag, "status", int'(rsp_status), exp_st);
      if (c_idx && exp_st == 0) chk(tag, "index", int'(rsp_idx), exp_idx);
      if (c_pin && exp_st == 0) chk(tag, "pin count", int'(rsp_pin), exp_pin);
      chk("R5", "latency", lat, exp_lat);
      if (is_scan) chk("R5", "ready low during scan", int'(ready_bad), 0);
      @(negedge clk);
      chk("R5", "single response pulse", int'(rsp_valid), 0);
   endtask

   initial begin
      for (int j = 0; j < N; j++) begin
         m_ord[j] = j; m_pin[j] = 0; m_mem[j] = 1;
      end
      m_len = N;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", int'(cmd_ready), 1);
      chk("R1", "no response after reset", int'(rsp_valid), 0);

      // R1 first grant is index 0
      run_op(0, 0, 8'h00, 0, "R1");
      // R3 busy entries rotated, idle 3 chosen
      run_op(0, 0, 8'b0000_0110, 0, "R3");
      // R3 every entry busy: fallback chosen
      run_op(0, 0, 8'hFF, 0, "R3");
      // R6 saturation
      for (int k = 0; k < 4; k++) run_op(1, 0, 8'h00, 0, "R6");
      // R7 unpin down to an error at zero
      for (int k = 0; k < 4; k++) run_op(2, 0, 8'h00, 0, "R7");
      // R4 fill the pool, then NO_RESOURCE and RETRY
      for (int k = 0; k < 8; k++) run_op(0, 0, 8'h00, 0, "");
      run_op(0, 0, 8'h00, 0, "R4");
      run_op(0, 0, 8'hA5, 1, "R4");
      // R8 release of a pinned register fails; after unpin it goes to the head
      run_op(3, 5, 8'h00, 0, "R8");
      run_op(2, 5, 8'h00, 0, "R7");
      run_op(3, 5, 8'h00, 0, "R8");
      run_op(0, 0, 8'h00, 0, "R8");
      // R9 lend with fewer than two unpinned fails
      run_op(2, 5, 8'h00, 0, "");
      run_op(4, 0, 8'h00, 0, "R9");
      run_op(2, 6, 8'h00, 0, "");
      run_op(4, 0, 8'h00, 0, "R9");
      // R6 touching a lent register fails; R10 take back and double take back
      for (int k = 0; k < N; k++) run_op(1, k, 8'h00, 0, "");
      for (int k = 0; k < N; k++) run_op(5, k, 8'h00, 0, "R10");
      for (int k = 0; k < N; k++) begin
         while (m_pin[k] > 0) run_op(2, k, 8'h00, 0, "");
      end
      run_op(0, 0, 8'h00, 0, "R10");

      // mixed sweep
      for (int k = 0; k < 4000; k++) begin
         int r = $urandom_range(99);
         int op;
         logic [N-1:0] bz;
         if (r < 30) op = 0;
         else if (r < 42) op = 1;
         else if (r < 68) op = 2;
         else if (r < 78) op = 3;
         else if (r < 89) op = 4;
         else op = 5;
         bz = N'($urandom) & N'($urandom);
         if ($urandom_range(9) == 0) bz = '1;
         run_op(op, $urandom_range(N - 1), bz, 1'($urandom_range(1)), "");
      end
      finish_run();
   end

endmodule